// File: doc/BRIEF.md
# Scaled Watchdog Timer

This block is a watchdog timer with a byte-wide down-counter. The counter counts either in seconds or in minutes, and its time base is a 1 Hz tick strobe. Software controls it through three byte registers on a plain write-enable, address and data port, and reads come back combinationally. A control register holds the unit select and two option bits. A count register arms the timer and reads back the remaining count. A status register holds the activity-reload enables, a one-shot force bit, a sticky fired flag and a 4-bit interrupt selector.

The counter can be held off by peripheral activity: a keyboard or mouse interrupt strobe restores the last programmed count. An expiry can also be forced, either by software or by an external keyboard line. On expiry the block latches the fired flag and pulses a timeout output for one cycle. When enabled, it also pulses a keyboard-reset output, and it pulses the selected interrupt line. Further expiries stay silent until software clears the fired flag.

Top module: `wdg_unit`

## Requirements
- R1: After reset the control, count and status registers read 0x00, and timeout_o, kbrst_o and irq_o are low.
- R2: Writing a nonzero value N to the count register (0xF6) loads and arms the counter, and a read of 0xF6 returns N in the following cycle. Writing 0 disables the timer: ticks leave the count at 0 and produce no timeout.
- R3: With control bit 3 clear (unit of one second), an armed counter decrements by one on each tick_1hz_i strobe.
- R4: With control bit 3 set (unit of one minute), the counter decrements once per 60 ticks. The tick prescaler restarts whenever the counter is loaded or reloaded.
- R5: When a decrement reaches zero, status bit 4 (fired) is set and the counter stays at 0. timeout_o is high for exactly one cycle, in the cycle after the expiring edge.
- R6: kbrst_o pulses together with timeout_o only if control bit 1 is set. Otherwise it stays low.
- R7: Status bits 3:0 select an interrupt line n. On a timeout only irq_o[n] pulses, together with timeout_o. A selector value of 0 drives no line.
- R8: Status bit 7 enables reload on mouse_irq_i and status bit 6 enables reload on kbd_irq_i. An enabled strobe restores the count last written to 0xF6. A strobe has no effect while the count is 0 or while its enable bit is clear.
- R9: Writing status bit 5 as 1 forces an immediate expiry: the count goes to 0 and the outputs pulse as in R5. Status bit 5 always reads as 0.
- R10: With control bit 2 set, a high kbd_p20_i forces an expiry as in R9. With control bit 2 clear, kbd_p20_i has no effect.
- R11: The fired bit stays set until software writes status bit 4 as 0. Writing bit 4 as 1 leaves it set. While it is set, no expiry produces a pulse on timeout_o, kbrst_o or irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz_i | input | 1 | One-cycle strobe once per second |
| kbd_irq_i | input | 1 | Keyboard interrupt strobe |
| mouse_irq_i | input | 1 | Mouse interrupt strobe |
| kbd_p20_i | input | 1 | External keyboard line that can force expiry |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | ADDR_W | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data for cfg_addr_i |
| timeout_o | output | 1 | One-cycle expiry pulse |
| kbrst_o | output | 1 | One-cycle keyboard-reset pulse |
| irq_o | output | IRQ_LINES | One-hot interrupt pulse on the selected line |

## Verification
The checker watches the counter and the output pulses on every cycle. It checks that a write loads the count, that a disabled count stays at zero, and that a plain step subtracts exactly one. It also checks that a forced expiry clears the count, that each expiry sets the fired flag with a single-cycle timeout, that the reset and interrupt pulses never appear without a timeout, and that a set fired flag keeps the outputs quiet. Only the bench's scenarios can show the end-to-end timing: the 60-tick minute period, the prescaler restart on a rewrite, the reload value restored by each enabled strobe, the ignored strobes, and the register read-back encodings.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 4;

  // Control register bit positions
  localparam int unsigned CB_MINUTE = 3;
  localparam int unsigned CB_P20EN  = 2;
  localparam int unsigned CB_KBRST  = 1;

  // Status register bit positions
  localparam int unsigned SB_MOUSE = 7;
  localparam int unsigned SB_KEYB  = 6;
  localparam int unsigned SB_FORCE = 5;
  localparam int unsigned SB_FIRED = 4;

  // One counting unit elapses on a tick when seconds are selected,
  // or on the last tick of the prescaler period when minutes are.
  function automatic logic unit_step(logic tick, logic minute, logic at_last);
    return tick && (!minute || at_last);
  endfunction

  // Next prescaler value on a tick: wrap at the end of the period.
  function automatic int unsigned pre_next(int unsigned cur, int unsigned period);
    return (cur + 1 >= period) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int unsigned PERIOD = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic minute_i,
  input  logic restart_i,
  output logic step_o
);
  localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] pre_q;
  logic          at_last;

  assign at_last = (pre_q == PW'(PERIOD - 1));
  assign step_o  = wdg_pkg::unit_step(tick_i, minute_i, at_last);

  always_ff @(posedge clk) begin
    if (!rst_n)                      pre_q <= '0;
    else if (restart_i || !minute_i) pre_q <= '0;
    else if (tick_i)                 pre_q <= PW'(wdg_pkg::pre_next(int'(pre_q), PERIOD));
  end
endmodule

// File: rtl/wdg_downcount.sv
module wdg_downcount #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          trig_i,
  input  logic          activity_i,
  input  logic          step_i,
  output logic [CW-1:0] count_o,
  output logic          armed_o,
  output logic          act_take_o,
  output logic          zero_hit_o
);
  logic [CW-1:0] cnt_q, rv_q;

  assign armed_o    = (cnt_q != '0);
  assign act_take_o = armed_o && activity_i && !load_i && !trig_i;
  assign zero_hit_o = armed_o && step_i && (cnt_q == CW'(1))
                      && !load_i && !trig_i && !act_take_o;
  assign count_o    = cnt_q;

  // Priority: software load, forced expiry, activity reload, unit step
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rv_q  <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      rv_q  <= load_val_i;
    end else if (trig_i) begin
      cnt_q <= '0;
    end else if (act_take_o) begin
      cnt_q <= rv_q;
    end else if (armed_o && step_i) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_CTRL = 'hF5,
  parameter logic [ADDR_W-1:0] A_CNT  = 'hF6,
  parameter logic [ADDR_W-1:0] A_STAT = 'hF7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [wdg_pkg::BYTE_W-1:0] wdata_i,
  input  logic                      fire_i,
  input  logic [wdg_pkg::BYTE_W-1:0] count_i,
  output logic [wdg_pkg::BYTE_W-1:0] rdata_o,
  output logic                      minute_o,
  output logic                      p20_en_o,
  output logic                      kbrst_en_o,
  output logic                      ms_en_o,
  output logic                      kb_en_o,
  output logic [wdg_pkg::SEL_W-1:0] sel_o,
  output logic                      fired_o,
  output logic                      force_o,
  output logic                      cnt_we_o
);
  import wdg_pkg::*;

  logic [BYTE_W-1:0] ctrl_q;
  logic              ms_q, kb_q, fired_q;
  logic [SEL_W-1:0]  sel_q;
  logic              stat_we;

  assign stat_we  = we_i && (addr_i == A_STAT);
  assign cnt_we_o = we_i && (addr_i == A_CNT);
  assign force_o  = stat_we && wdata_i[SB_FORCE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ms_q    <= 1'b0;
      kb_q    <= 1'b0;
      sel_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (we_i && (addr_i == A_CTRL)) ctrl_q <= wdata_i;
      if (stat_we) begin
        ms_q  <= wdata_i[SB_MOUSE];
        kb_q  <= wdata_i[SB_KEYB];
        sel_q <= wdata_i[SEL_W-1:0];
      end
      if (fire_i)                             fired_q <= 1'b1;
      else if (stat_we && !wdata_i[SB_FIRED]) fired_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)      rdata_o = ctrl_q;
    else if (addr_i == A_CNT)  rdata_o = count_i;
    else if (addr_i == A_STAT) rdata_o = {ms_q, kb_q, 1'b0, fired_q, sel_q};
  end

  assign minute_o   = ctrl_q[CB_MINUTE];
  assign p20_en_o   = ctrl_q[CB_P20EN];
  assign kbrst_en_o = ctrl_q[CB_KBRST];
  assign ms_en_o    = ms_q;
  assign kb_en_o    = kb_q;
  assign sel_o      = sel_q;
  assign fired_o    = fired_q;
endmodule

// File: rtl/wdg_unit.sv
module wdg_unit #(
  parameter int unsigned ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] A_CTRL  = 'hF5,
  parameter logic [ADDR_W-1:0] A_CNT   = 'hF6,
  parameter logic [ADDR_W-1:0] A_STAT  = 'hF7,
  parameter int unsigned TICKS_PER_MIN = 60,
  parameter int unsigned IRQ_LINES     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_1hz_i,
  input  logic                 kbd_irq_i,
  input  logic                 mouse_irq_i,
  input  logic                 kbd_p20_i,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [7:0]           cfg_wdata_i,
  output logic [7:0]           cfg_rdata_o,
  output logic                 timeout_o,
  output logic                 kbrst_o,
  output logic [IRQ_LINES-1:0] irq_o
);
  import wdg_pkg::*;

  logic             minute, p20_en, kbrst_en, ms_en, kb_en, fired;
  logic [SEL_W-1:0] sel;
  logic             force_wr, cnt_load;
  logic [7:0]       count;
  logic             armed, act_reload, zero_hit, step;
  logic             trig, activity, fire_evt, restart;

  wdg_regs #(
    .ADDR_W(ADDR_W), .A_CTRL(A_CTRL), .A_CNT(A_CNT), .A_STAT(A_STAT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .fire_i(fire_evt), .count_i(count),
    .rdata_o(cfg_rdata_o), .minute_o(minute), .p20_en_o(p20_en),
    .kbrst_en_o(kbrst_en), .ms_en_o(ms_en), .kb_en_o(kb_en),
    .sel_o(sel), .fired_o(fired), .force_o(force_wr), .cnt_we_o(cnt_load)
  );

  assign trig     = force_wr || (p20_en && kbd_p20_i);
  assign activity = (kb_en && kbd_irq_i) || (ms_en && mouse_irq_i);
  assign restart  = cnt_load || act_reload;

  wdg_prescale #(.PERIOD(TICKS_PER_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_1hz_i), .minute_i(minute),
    .restart_i(restart), .step_o(step)
  );

  wdg_downcount #(.CW(8)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(cnt_load), .load_val_i(cfg_wdata_i),
    .trig_i(trig), .activity_i(activity), .step_i(step),
    .count_o(count), .armed_o(armed), .act_take_o(act_reload),
    .zero_hit_o(zero_hit)
  );

  assign fire_evt = (trig || zero_hit) && !fired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timeout_o <= 1'b0;
      kbrst_o   <= 1'b0;
    end else begin
      timeout_o <= fire_evt;
      kbrst_o   <= fire_evt && kbrst_en;
    end
  end

  for (genvar i = 0; i < IRQ_LINES; i++) begin : g_irq
    if (i == 0) begin : g_none
      assign irq_o[i] = 1'b0;
    end else begin : g_line
      logic line_q;
      always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= fire_evt && (sel == SEL_W'(i));
      end
      assign irq_o[i] = line_q;
    end
  end
endmodule

// File: rtl/wdg_unit_chk.sv
module wdg_unit_chk #(
  parameter int unsigned IRQ_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [7:0]           cfg_wdata_i,
  input logic [7:0]           count,
  input logic                 armed,
  input logic                 step,
  input logic                 trig,
  input logic                 cnt_load,
  input logic                 act_reload,
  input logic                 fire_evt,
  input logic                 fired,
  input logic                 timeout_o,
  input logic                 kbrst_o,
  input logic [IRQ_LINES-1:0] irq_o
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> count == $past(cfg_wdata_i)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 8'd0 && !cnt_load) |=> count == 8'd0); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && step && !cnt_load && !trig && !act_reload) |=> count == $past(count) - 8'd1); // R3
  AST_FIRE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> (timeout_o && fired)); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o); // R5
  AST_KBRST_WITH_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    kbrst_o |-> timeout_o); // R6
  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o)); // R7
  AST_IRQ_WITH_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> timeout_o); // R7
  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !cnt_load) |=> count == 8'd0); // R9
  AST_FIRED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fired |=> !timeout_o); // R11
endmodule

bind wdg_unit wdg_unit_chk #(.IRQ_LINES(IRQ_LINES)) u_chk (.*);

// File: tb/wdg_unit_test.sv
module wdg_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, kbd = 1'b0, mouse = 1'b0, p20 = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00, wdata = 8'h00;
  logic [7:0]  rdata;
  logic        timeout, kbrst;
  logic [15:0] irq;

  always #5 clk = ~clk;

  wdg_unit uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz_i(tick), .kbd_irq_i(kbd),
    .mouse_irq_i(mouse), .kbd_p20_i(p20), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .timeout_o(timeout),
    .kbrst_o(kbrst), .irq_o(irq)
  );

  localparam logic [7:0] CTRL = 8'hF5, CNT = 8'hF6, STAT = 8'hF7;

  typedef struct {
    int unsigned due;
    logic        kb;
    logic [15:0] line;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int unsigned cyc = 0;
  int          n_cmp = 0, n_bad = 0;
  string       phase = "R1";
  logic        pend = 1'b0;
  exp_t        pend_item;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: pops expected expiry events and compares as they appear
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (timeout) begin
        if (sbq.size() == 0) begin
          check({phase, " unexpected timeout"}, 32'd1, 32'd0);
        end else begin
          e = sbq.pop_front();
          check({e.tag, " timeout cycle"}, cyc, e.due);
          check({e.tag, " kbrst"}, {31'd0, kbrst}, {31'd0, e.kb});
          check({e.tag, " irq"}, {16'd0, irq}, {16'd0, e.line});
        end
      end else begin
        if (kbrst || irq != 16'd0)
          check({phase, " stray pulse"}, {15'd0, kbrst, irq}, 32'd0);
        if (sbq.size() != 0 && sbq[0].due <= cyc) begin
          e = sbq.pop_front();
          check({e.tag, " missing timeout"}, 32'd0, 32'd1);
        end
      end
    end
  end

  // Driver helpers: an armed expectation is pushed at the stimulus edge
  task automatic arm(logic kb, logic [15:0] line, string tag);
    pend = 1'b1;
    pend_item.kb = kb;
    pend_item.line = line;
    pend_item.tag = tag;
  endtask

  task automatic drop();
    if (pend) begin
      pend_item.due = cyc + 1;
      sbq.push_back(pend_item);
      pend = 1'b0;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); drop();
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); drop();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic strobe(logic k, logic m, logic p);
    @(negedge clk); drop();
    kbd = k; mouse = m; p20 = p;
    @(negedge clk);
    kbd = 1'b0; mouse = 1'b0; p20 = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, {24'd0, rdata}, {24'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(CTRL, 8'h00, "R1 ctrl");
    rd(CNT,  8'h00, "R1 count");
    rd(STAT, 8'h00, "R1 status");
    check("R1 outputs", {15'd0, timeout, kbrst, irq}, 32'd0);

    // R2 load, R3 seconds countdown, R5/R6/R7 expiry
    phase = "R3";
    wr(CNT, 8'd3);
    rd(CNT, 8'd3, "R2 load");
    ticks(1); rd(CNT, 8'd2, "R3 step");
    ticks(1); rd(CNT, 8'd1, "R3 step");
    wr(CTRL, 8'h02); wr(STAT, 8'h05);
    arm(1'b1, 16'h0020, "R5 R6 R7 expiry");
    ticks(1);
    rd(CNT, 8'd0, "R5 stopped");
    rd(STAT, 8'h15, "R5 fired bit");
    ticks(2);
    rd(CNT, 8'd0, "R5 stays zero");

    // R11 sticky fired, silent expiry
    phase = "R11";
    wr(CNT, 8'd2);
    ticks(2);
    rd(CNT, 8'd0, "R11 silent countdown");
    rd(STAT, 8'h15, "R11 still fired");
    wr(STAT, 8'h15);
    rd(STAT, 8'h15, "R11 write one keeps");
    wr(STAT, 8'h05);
    rd(STAT, 8'h05, "R11 cleared");

    // R2 disabled, R8 reload ignored when disabled
    phase = "R8";
    wr(CNT, 8'd0);
    ticks(3);
    rd(CNT, 8'd0, "R2 disabled");
    wr(STAT, 8'hC5);
    strobe(1'b1, 1'b1, 1'b0);
    rd(CNT, 8'd0, "R8 disabled reload ignored");
    wr(CNT, 8'd4);
    ticks(2); rd(CNT, 8'd2, "R3 two steps");
    strobe(1'b1, 1'b0, 1'b0); rd(CNT, 8'd4, "R8 keyboard reload");
    ticks(1); rd(CNT, 8'd3, "R3 step");
    strobe(1'b0, 1'b1, 1'b0); rd(CNT, 8'd4, "R8 mouse reload");
    wr(STAT, 8'h85);
    ticks(1); rd(CNT, 8'd3, "R3 step");
    strobe(1'b1, 1'b0, 1'b0); rd(CNT, 8'd3, "R8 keyboard disabled");

    // R9 forced expiry
    phase = "R9";
    arm(1'b1, 16'h0020, "R9 force");
    wr(STAT, 8'hA5);
    rd(STAT, 8'h95, "R9 force bit reads zero");
    rd(CNT, 8'd0, "R9 count cleared");
    wr(STAT, 8'h03);
    wr(CTRL, 8'h08);

    // R4 minute unit and prescaler restart
    phase = "R4";
    wr(CNT, 8'd2);
    ticks(59); rd(CNT, 8'd2, "R4 before period end");
    ticks(1);  rd(CNT, 8'd1, "R4 one minute");
    ticks(30);
    wr(CNT, 8'd2);
    ticks(59); rd(CNT, 8'd2, "R4 prescaler restarted");
    ticks(1);  rd(CNT, 8'd1, "R4 one minute after rewrite");
    ticks(59); rd(CNT, 8'd1, "R4 second minute pending");
    arm(1'b0, 16'h0008, "R4 R6 R7 minute expiry");
    ticks(1);
    rd(CNT, 8'd0, "R4 expired");

    // R10 keyboard line forcing, R7 selector zero
    phase = "R10";
    wr(STAT, 8'h00);
    wr(CTRL, 8'h04);
    wr(CNT, 8'd9);
    arm(1'b0, 16'h0000, "R10 R7 line force");
    strobe(1'b0, 1'b0, 1'b1);
    rd(CNT, 8'd0, "R10 count cleared");
    rd(STAT, 8'h10, "R10 fired");
    wr(STAT, 8'h00);
    wr(CTRL, 8'h00);
    wr(CNT, 8'd9);
    strobe(1'b0, 1'b0, 1'b1);
    rd(CNT, 8'd9, "R10 line ignored");
    rd(STAT, 8'h00, "R10 not fired");

    repeat (4) @(negedge clk);
    while (sbq.size() != 0) begin
      exp_t e;
      e = sbq.pop_front();
      check({e.tag, " never seen"}, 32'd0, 32'd1);
    end
    summary();
    $finish;
  end
endmodule